// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Sequencer

This block turns a single PWM command into two gate enables for a half bridge: one for the high-side switch and one for the low-side switch. It never closes both switches together. It does not use a fixed dead time. Instead it waits for evidence from digital comparator flags that the switch turning off has really gone off.

When PWM falls, the high side is released after a fixed delay. The low side is then enabled when one of two things happens:
- the switch node is sensed low for long enough;
- a switch-node latch has been set, either by a lower-threshold flag or by a fallback timeout.

The latch can only be cleared by PWM going high again. Ringing on the switch node therefore cannot toggle the low side off again. When PWM rises, the low side is released after a fixed delay. The high side is enabled only once a low-gate-off flag confirms the low-side gate has discharged.

All delays are parameters in nanoseconds. They are turned into clock cycles from a clock-period parameter. The defaults assume a 10 ns clock. The three flag inputs each pass through a synchronizer, and that latency is counted inside the configured delays.

Top module: `hb_deadtime_seq`

## Requirements
Edge numbering: E is the clock edge at which `pwm_i` is first sampled low, R the edge at which it is first sampled high; the first edge after reset release counts as E or R for whichever level it samples. Defaults give 4 cycles for each 35 ns delay, 8 for the 80 ns minimum and 25 for the 250 ns fallback; each flag passes two synchronizer flops.
- R1: During reset `hi_en_o`, `lo_en_o` and `latch_o` are 0. The first edge after release takes the current `pwm_i` level as a fresh edge.
- R2: A high-side enable that is set drops at edge E+3.
- R3: With `sw_low_i` held high from the edge a that first samples it, `lo_en_o` rises at edge max(a+3, E+7), provided `pwm_i` stays low.
- R4: `latch_o` rises at edge min(a+2, E+24) while `pwm_i` stays low, where a is the first edge sampling `sw_latch_i` high. It is never set while `pwm_i` is high.
- R5: Once the latch is set, `lo_en_o` rises on the next edge, but never before edge E+7.
- R6: Once `lo_en_o` is set it stays set for as long as `pwm_i` stays low, even while `sw_low_i` toggles. `latch_o` clears only at edge R.
- R7: A low-side enable that is set drops at edge R+3.
- R8: With `lo_off_i` held high from edge b, `hi_en_o` rises at edge max(R+1, b+3, one edge after `lo_en_o` dropped), provided `pwm_i` stays high.
- R9: `hi_en_o` and `lo_en_o` are never high together.
- R10: If `pwm_i` rises before `lo_en_o` has risen, the pending low-side turn-on is dropped. The high side then follows R8 with no low-side delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_i | input | 1 | PWM command, high selects the high-side switch |
| sw_low_i | input | 1 | Switch node below its upper threshold (asynchronous) |
| sw_latch_i | input | 1 | Switch node below its lower, latch-setting threshold (asynchronous) |
| lo_off_i | input | 1 | Low-side gate voltage below its off threshold (asynchronous) |
| hi_en_o | output | 1 | High-side gate enable |
| lo_en_o | output | 1 | Low-side gate enable |
| latch_o | output | 1 | Switch-node latch state |

## Verification
Every result falls due on a known edge counted from the PWM edge or from the edge that first samples a flag:
- the high side drops three edges after E, and the low side three edges after R;
- the latch sets two edges after its flag is sampled, or at E+24;
- the low side rises no earlier than E+7;
- the high side rises three edges after its flag is sampled.

The bench drives inputs at the falling clock edge and logs the edge number of every output transition. At the end of each PWM phase it compares those edge numbers with values worked out from the formulas above. A transition that is missing or comes one edge early or late therefore fails its check.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_t;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hbd_qual.sv
module hbd_qual #(
   parameter int THR = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic s,
   output logic ok
);

   generate
      if (THR == 0) begin : g_direct
         assign ok = s;
      end else begin : g_count
         localparam int CW = $clog2(THR + 1);
         logic [CW-1:0] run;

         always_ff @(posedge clk) begin
            if (rst || !s) begin
               run <= '0;
            end else if (run != CW'(THR)) begin
               run <= run + 1'b1;
            end
         end

         assign ok = s && (run == CW'(THR));
      end
   endgenerate

endmodule

// File: rtl/hbd_pwm_tmr.sv
module hbd_pwm_tmr #(
   parameter int MAXC = 24,
   parameter int TW   = $clog2(MAXC + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          first,
   input  logic          pwm,
   output logic          rise,
   output logic          fall,
   output logic [TW-1:0] tmr
);

   logic pwm_q;

   assign rise = first ? pwm  : (pwm & ~pwm_q);
   assign fall = first ? ~pwm : (~pwm & pwm_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         pwm_q <= 1'b0;
         tmr   <= '0;
      end else begin
         pwm_q <= pwm;
         if (rise || fall) begin
            tmr <= TW'(1);
         end else if (tmr != TW'(MAXC)) begin
            tmr <= tmr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq
   import hbd_pkg::*;
#(
   parameter int CLK_NS       = 10,
   parameter int HS_OFF_NS    = 35,
   parameter int LS_ON_NS     = 35,
   parameter int LS_OFF_NS    = 35,
   parameter int HS_ON_NS     = 35,
   parameter int LS_MIN_NS    = 80,
   parameter int LATCH_TMO_NS = 250,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pwm_i,
   input  logic sw_low_i,
   input  logic sw_latch_i,
   input  logic lo_off_i,
   output logic hi_en_o,
   output logic lo_en_o,
   output logic latch_o
);

   localparam int T_HOFF = ns_to_cyc(HS_OFF_NS, CLK_NS);
   localparam int T_LON  = ns_to_cyc(LS_ON_NS, CLK_NS);
   localparam int T_LOFF = ns_to_cyc(LS_OFF_NS, CLK_NS);
   localparam int T_HON  = ns_to_cyc(HS_ON_NS, CLK_NS);
   localparam int T_MIN  = ns_to_cyc(LS_MIN_NS, CLK_NS);
   localparam int T_FB   = ns_to_cyc(LATCH_TMO_NS, CLK_NS);

   // edge-relative thresholds: the timer reads j at the j-th edge after a PWM edge
   localparam int TH_HOFF = T_HOFF - 1;
   localparam int TH_LOFF = T_LOFF - 1;
   localparam int TH_MIN  = T_MIN - 1;
   localparam int TH_FB   = T_FB - 1;
   // flag qualifiers: synchronizer stages already cover part of the delay
   localparam int Q_LON   = T_LON - SYNC_STAGES - 1;
   localparam int Q_HON   = T_HON - SYNC_STAGES - 1;

   localparam int MAXC = max_of4(TH_HOFF, TH_LOFF, TH_MIN, TH_FB);
   localparam int TW   = $clog2(MAXC + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (T_HOFF < 2 || T_LOFF < 2) begin : g_bad_off
         $error("turn-off delays must span at least two clock cycles");
      end
      if (Q_LON < 0 || Q_HON < 0) begin : g_bad_on
         $error("turn-on delays must exceed the synchronizer latency");
      end
      if (T_MIN <= T_HOFF) begin : g_bad_min
         $error("low-side minimum delay must exceed the high-side turn-off delay");
      end
      if (T_FB < T_MIN) begin : g_bad_fb
         $error("fallback timeout must not be shorter than the minimum delay");
      end
   endgenerate

   phase_t        phase;
   logic [2:0]    flags_s;
   logic          sw_ok, go_ok, q_latch;
   logic          rise, fall;
   logic [TW-1:0] tmr;
   logic          hi_q, lo_q, lat_q;
   logic          hi_n, lo_n, lat_n;

   hbd_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({lo_off_i, sw_latch_i, sw_low_i}),
      .q   (flags_s)
   );

   assign q_latch = flags_s[1];

   hbd_qual #(.THR(Q_LON)) u_qual_sw (
      .clk (clk),
      .rst (rst),
      .s   (flags_s[0]),
      .ok  (sw_ok)
   );

   hbd_qual #(.THR(Q_HON)) u_qual_go (
      .clk (clk),
      .rst (rst),
      .s   (flags_s[2]),
      .ok  (go_ok)
   );

   hbd_pwm_tmr #(.MAXC(MAXC), .TW(TW)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .first (phase == PH_IDLE),
      .pwm   (pwm_i),
      .rise  (rise),
      .fall  (fall),
      .tmr   (tmr)
   );

   always_comb begin
      hi_n  = hi_q;
      lo_n  = lo_q;
      lat_n = lat_q;
      if (pwm_i) begin
         if (rise) begin
            lat_n = 1'b0;
         end else begin
            if (tmr >= TW'(TH_LOFF)) lo_n = 1'b0;
            if (!lo_q && go_ok)      hi_n = 1'b1;
         end
      end else if (!fall) begin
         if (tmr >= TW'(TH_HOFF))             hi_n  = 1'b0;
         if (q_latch || tmr >= TW'(TH_FB))    lat_n = 1'b1;
         if (!hi_q && tmr >= TW'(TH_MIN) && (lat_q || sw_ok)) lo_n = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         hi_q  <= 1'b0;
         lo_q  <= 1'b0;
         lat_q <= 1'b0;
      end else begin
         phase <= PH_RUN;
         hi_q  <= hi_n;
         lo_q  <= lo_n;
         lat_q <= lat_n;
      end
   end

   assign hi_en_o = hi_q;
   assign lo_en_o = lo_q;
   assign latch_o = lat_q;

endmodule

// File: rtl/hbd_chk.sv
module hbd_chk (
   input logic clk,
   input logic rst,
   input logic pwm_i,
   input logic hi_en_o,
   input logic lo_en_o,
   input logic latch_o
);

   a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(hi_en_o && lo_en_o));

   a_r8_hi_rise_pwm_high: assert property (@(posedge clk) disable iff (rst)
      $rose(hi_en_o) |-> $past(pwm_i));

   a_r2_hi_fall_pwm_low: assert property (@(posedge clk) disable iff (rst)
      $fell(hi_en_o) |-> !$past(pwm_i));

   a_r3_lo_rise_pwm_low: assert property (@(posedge clk) disable iff (rst)
      $rose(lo_en_o) |-> !$past(pwm_i));

   a_r7_lo_fall_after_rise: assert property (@(posedge clk) disable iff (rst)
      $fell(lo_en_o) |-> ($past(pwm_i) && $past(pwm_i, 2)));

   a_r6_latch_clear_on_rise: assert property (@(posedge clk) disable iff (rst)
      $fell(latch_o) |-> $past(pwm_i));

   a_r4_latch_set_pwm_low: assert property (@(posedge clk) disable iff (rst)
      $rose(latch_o) |-> !$past(pwm_i));

endmodule

bind hb_deadtime_seq hbd_chk u_hbd_chk (
   .clk     (clk),
   .rst     (rst),
   .pwm_i   (pwm_i),
   .hi_en_o (hi_en_o),
   .lo_en_o (lo_en_o),
   .latch_o (latch_o)
);

// File: tb/test_hb_deadtime_seq.sv
module test_hb_deadtime_seq;

   localparam int D_HOFF = 4;
   localparam int D_LON  = 4;
   localparam int D_LOFF = 4;
   localparam int D_HON  = 4;
   localparam int D_MIN  = 8;
   localparam int D_FB   = 25;
   localparam int NEVER  = 1 << 30;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pwm = 1'b0;
   logic swl = 1'b0;
   logic swt = 1'b0;
   logic lgo = 1'b0;
   logic hi, lo, lat;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int ph_id = 0;

   // monitor-owned records of the first transition edges in the current phase
   int seen_id = -1;
   int r_hi_rise, r_hi_fall, r_lo_rise, r_lo_fall, r_lat_rise, r_lat_fall, r_lo_n;
   int ovl_bad = 0;
   logic p_hi = 1'b0, p_lo = 1'b0, p_lat = 1'b0;

   hb_deadtime_seq i_hb_deadtime_seq (
      .clk        (clk),
      .rst        (rst),
      .pwm_i      (pwm),
      .sw_low_i   (swl),
      .sw_latch_i (swt),
      .lo_off_i   (lgo),
      .hi_en_o    (hi),
      .lo_en_o    (lo),
      .latch_o    (lat)
   );

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (seen_id != ph_id) begin
         seen_id    = ph_id;
         r_hi_rise  = -1; r_hi_fall  = -1;
         r_lo_rise  = -1; r_lo_fall  = -1;
         r_lat_rise = -1; r_lat_fall = -1;
         r_lo_n     = 0;
      end
      if (!rst) begin
         if (hi && !p_hi && r_hi_rise < 0) r_hi_rise = cyc;
         if (!hi && p_hi && r_hi_fall < 0) r_hi_fall = cyc;
         if (lo && !p_lo && r_lo_rise < 0) r_lo_rise = cyc;
         if (!lo && p_lo && r_lo_fall < 0) r_lo_fall = cyc;
         if (lat && !p_lat && r_lat_rise < 0) r_lat_rise = cyc;
         if (!lat && p_lat && r_lat_fall < 0) r_lat_fall = cyc;
         if (lo != p_lo) r_lo_n = r_lo_n + 1;
         if (hi && lo) ovl_bad = ovl_bad + 1;
      end
      p_hi = hi; p_lo = lo; p_lat = lat;
   end

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // high phase: pwm sampled high from edge R for len edges; lo_off raised at offset dg (<0 never)
   task automatic run_high(input int len, input int dg, input string htag);
      int r, y, lo_fall_exp, lat_fall_exp;
      bit hi_was, lo_was, lat_was;
      rst = 1'b0;
      pwm = 1'b1;
      swl = 1'b0;
      swt = 1'b0;
      lgo = 1'b0;
      hi_was = hi; lo_was = lo; lat_was = lat;
      r = cyc + 1;
      ph_id++;
      for (int k = 0; k < len; k++) begin
         if (k == dg) lgo = 1'b1;
         @(negedge clk);
      end
      #1;
      lo_fall_exp = lo_was ? r + D_LOFF - 1 : -1;
      if (lo_fall_exp > r + len - 1) lo_fall_exp = -1;
      lat_fall_exp = lat_was ? r : -1;
      if (dg < 0 || hi_was) begin
         y = -1;
      end else begin
         y = r + 1;
         if (lo_was) y = imax(y, r + D_LOFF);
         y = imax(y, r + dg + D_HON - 1);
         if (y > r + len - 1) y = -1;
      end
      chk(r_lo_fall == lo_fall_exp, "R7 lo_en fall edge", r_lo_fall - r, lo_fall_exp - r);
      chk(r_lat_fall == lat_fall_exp, "R6 latch clear edge", r_lat_fall - r, lat_fall_exp - r);
      chk(r_hi_rise == y, htag, r_hi_rise - r, y - r);
   endtask

   // low phase: pwm sampled low from edge E for len edges; flags at offsets ds / dl (<0 never)
   task automatic run_low(input int len, input int ds, input int dl, input bit ring);
      int e, hf, lr, cand, x;
      bit hi_was, lo_was;
      string ltag;
      pwm = 1'b0;
      lgo = 1'b0;
      hi_was = hi; lo_was = lo;
      e = cyc + 1;
      ph_id++;
      for (int k = 0; k < len; k++) begin
         if (k == ds) swl = 1'b1;
         else if (ring && ds >= 0 && k > ds) swl = ~swl;
         if (k == dl) swt = 1'b1;
         @(negedge clk);
      end
      #1;
      hf = hi_was ? e + D_HOFF - 1 : -1;
      lr = (dl >= 0) ? e + dl + 2 : NEVER;
      lr = imin(lr, e + D_FB - 1);
      if (lr > e + len - 1) lr = -1;
      cand = NEVER;
      if (lr >= 0) cand = lr + 1;
      if (ds >= 0 && !ring) cand = imin(cand, e + ds + D_LON - 1);
      x = imax(e + D_MIN - 1, cand);
      if (x > e + len - 1 || lo_was) x = -1;
      if (ring)                  ltag = "R6 lo_en rise under ringing";
      else if (x < 0)            ltag = "R10 lo_en stays low on early pwm rise";
      else if (lr >= 0 && cand == lr + 1) ltag = "R5 lo_en rise after latch";
      else                       ltag = "R3 lo_en rise on switch-node low";
      chk(r_hi_fall == hf, "R2 hi_en fall edge", r_hi_fall - e, hf - e);
      chk(r_lat_rise == lr, "R4 latch set edge", r_lat_rise - e, lr - e);
      chk(r_lo_rise == x, ltag, r_lo_rise - e, x - e);
      chk(r_lo_n == ((x >= 0) ? 1 : 0), "R6 lo_en toggles in low phase", r_lo_n, (x >= 0) ? 1 : 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL R1 watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd4605));
      repeat (3) @(negedge clk);
      chk(hi == 1'b0, "R1 hi_en in reset", int'(hi), 0);
      chk(lo == 1'b0, "R1 lo_en in reset", int'(lo), 0);
      chk(lat == 1'b0, "R1 latch in reset", int'(lat), 0);

      // first sample after reset is high: high side follows the gate-off flag
      run_high(8, 0, "R1 hi_en rise from idle");
      // no flags at all: fallback timeout sets latch, low side follows
      run_low(30, -1, -1, 1'b0);
      run_high(10, 2, "R8 hi_en rise after lo_off");
      // very fast switch node: minimum delay governs
      run_low(20, 0, -1, 1'b0);
      // gate-off flag never arrives: high side stays off
      run_high(10, -1, "R8 hi_en held without lo_off");
      // slow switch node: comparator path governs
      run_low(20, 10, -1, 1'b0);
      run_high(6, 0, "R8 hi_en rise after lo_off");
      // ringing switch node with latch flag
      run_low(20, 2, 5, 1'b1);
      run_high(6, 0, "R8 hi_en rise after lo_off");
      // pwm returns high before the low side turned on
      run_low(6, 0, -1, 1'b0);
      run_high(8, 0, "R10 hi_en rise after cancelled low side");
      // latch-threshold flag alone
      run_low(20, -1, 3, 1'b0);
      run_high(8, 1, "R8 hi_en rise after lo_off");

      for (int it = 0; it < 80; it++) begin
         int ll, ds, dl, hl, dg;
         bit rg;
         ll = 4 + int'($urandom % 37);
         ds = ($urandom % 4 == 0) ? -1 : int'($urandom % 30);
         dl = ($urandom % 3 == 0) ? -1 : int'($urandom % 30);
         rg = ($urandom % 4 == 0);
         hl = 4 + int'($urandom % 17);
         dg = ($urandom % 5 == 0) ? -1 : int'($urandom % 12);
         run_low(ll, ds, dl, rg);
         run_high(hl, dg, "R8 hi_en rise edge");
      end

      chk(ovl_bad == 0, "R9 enables overlapping cycles", ovl_bad, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule